// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the bus-side engine of a processor whose address and data share one set of pins. The processor is the only master and drives every control line itself. A request brings an address, a direction (read or write), a space (memory or I/O), a size (byte or 16-bit word) and write data. The block turns it into a four-phase bus cycle, T1 to T4, with optional wait phases. The address goes out on the shared lines in T1 under an address strobe. Data moves on the same lines from T2 onward, and the outcome comes back as read data plus a one-cycle completion flag.

Byte lanes are picked with an active-low high-byte enable and address bit 0. A transparent latch inside the block rebuilds the full, demultiplexed address from the strobe. Slow devices stretch the cycle by holding the ready input low at the end of T3. A request is taken only while the sequencer is idle.

Top module: `mbus_seq`

## Requirements
- R1: While rst_n is low, and in the idle phase, the block shows an inactive bus: bus_ale=0, bus_rd_n=1, bus_wr_n=1, bus_ad_oe=0, bus_bhe_n=1, bus_mem=0, bus_ad_out=0, bus_a_hi=0, rsp_done=0. rsp_rdata resets to 0.
- R2: req_valid sampled high at a clock edge in the idle phase starts T1 in the next cycle. For exactly that one cycle, bus_ale=1, bus_ad_oe=1 and bus_ad_out carries address bits 15..1 with the A0 value of R4 in bit 0. bus_a_hi carries address bits ADDR_W-1..16 from T1 through T4. The phases then follow T1, T2, T3, optional waits, T4, idle.
- R3: bus_mem is the inverse of req_io (1 = memory space). It is held constant from T1 through T4.
- R4: Lane select, held from T1 through T4: a word access gives A0=0 and bus_bhe_n=0; a byte access at an even address gives A0=0 and bus_bhe_n=1; a byte access at an odd address gives A0=1 and bus_bhe_n=0.
- R5: In a read, the shared lines are released (bus_ad_oe=0) from T2 through T4. bus_rd_n is low in T2, T3 and every wait phase, and high in T4.
- R6: In a write, bus_wr_n is low from T2 through T4. bus_ad_oe=1 with the write data on bus_ad_out for the same span.
- R7: A word write drives req_wdata unchanged. A byte write drives req_wdata[7:0] on both lanes, bits 7..0 and bits 15..8.
- R8: bus_ready is sampled only at the clock edge that ends T3 or a wait phase. Low there inserts (another) wait phase; high moves to T4. Its level in any other phase has no effect.
- R9: Read data is captured from bus_ad_in at the edge where R8 moves to T4. A word read returns all 16 bits. A byte read returns the selected lane (bits 7..0 for even, bits 15..8 for odd) in rsp_rdata[7:0] with the upper byte zero. rsp_rdata holds until the next read capture.
- R10: rsp_done is high for exactly the T4 cycle of every transfer.
- R11: req_valid outside the idle phase is ignored: the running transfer is unchanged and no new cycle starts from it.
- R12: lat_addr follows {bus_a_hi, bus_ad_out} while bus_ale is high. It keeps the T1 address after bus_ale falls, until the next T1. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, taken in the idle phase |
| req_addr | input | ADDR_W | Byte address of the transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_wdata | input | 2*LANE_W | Write data (byte writes use bits 7..0) |
| rsp_done | output | 1 | High during T4 |
| rsp_rdata | output | 2*LANE_W | Read result |
| bus_ale | output | 1 | Address strobe, high in T1 |
| bus_mem | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_bhe_n | output | 1 | Active-low high-byte enable |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ad_out | output | 2*LANE_W | Shared address/data lines, outbound value |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | 2*LANE_W | Shared address/data lines, inbound value |
| bus_a_hi | output | ADDR_W-2*LANE_W | Upper address bits |
| bus_ready | input | 1 | Device ready, sampled at the end of T3 and waits |
| lat_addr | output | ADDR_W | Demultiplexed address from the internal latch |

## Verification
An accepted request shows its T1 outputs in the first cycle after the accepting edge, and each later phase comes one cycle after the one before it. Every wait inserted by a low ready at the end of T3 or a wait phase pushes T4 and rsp_done back by one cycle. Read data belongs to the edge that leaves T3 or the last wait, and it is visible in T4 alongside rsp_done. The bench drives inputs and samples outputs on the falling clock edge. At each posedge it advances a phase-counting model under the same inputs, then compares every output against that model in each cycle, so a result that comes one cycle early or late shows up as a mismatch.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_TW   = 3'd4,
      PH_T4   = 3'd5
   } bus_phase_e;

   // Phases in which the data part of the cycle owns the shared lines
   function automatic logic is_data_phase(bus_phase_e p);
      return (p == PH_T2) || (p == PH_T3) || (p == PH_TW) || (p == PH_T4);
   endfunction

   // Phases at whose closing edge the ready input is looked at
   function automatic logic is_ready_phase(bus_phase_e p);
      return (p == PH_T3) || (p == PH_TW);
   endfunction

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
   import mbus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       bus_ready,
   output bus_phase_e phase,
   output logic       accept,
   output logic       sample
);

   bus_phase_e phase_nx;

   assign accept = req_valid && (phase == PH_IDLE);
   assign sample = is_ready_phase(phase) && bus_ready;

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE: if (accept) phase_nx = PH_T1;
         PH_T1:   phase_nx = PH_T2;
         PH_T2:   phase_nx = PH_T3;
         PH_T3,
         PH_TW:   phase_nx = bus_ready ? PH_T4 : PH_TW;
         PH_T4:   phase_nx = PH_IDLE;
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nx;
   end

endmodule

// File: rtl/mbus_lane.sv
module mbus_lane #(
   parameter int LANE_W        = 8,
   parameter bit BYTE_RD_ALIGN = 1'b1
) (
   input  logic                  word,
   input  logic                  addr0,
   input  logic [2*LANE_W-1:0]   wdata,
   input  logic [2*LANE_W-1:0]   rd_raw,
   output logic                  a0,
   output logic                  bhe_n,
   output logic [2*LANE_W-1:0]   wlane,
   output logic [2*LANE_W-1:0]   rd_val
);

   localparam int DATA_W = 2 * LANE_W;

   logic [LANE_W-1:0] lo_in, hi_in;

   assign lo_in = rd_raw[LANE_W-1:0];
   assign hi_in = rd_raw[DATA_W-1:LANE_W];

   // Word accesses are always even; bytes follow the address bit
   assign a0    = word ? 1'b0 : addr0;
   assign bhe_n = ~(word | addr0);

   // A byte write appears on both lanes so either lane's device sees it
   assign wlane = word ? wdata : {2{wdata[LANE_W-1:0]}};

   generate
      if (BYTE_RD_ALIGN) begin : g_align
         always_comb begin
            if (word)       rd_val = rd_raw;
            else if (addr0) rd_val = {{LANE_W{1'b0}}, hi_in};
            else            rd_val = {{LANE_W{1'b0}}, lo_in};
         end
      end else begin : g_inplace
         always_comb begin
            if (word)       rd_val = rd_raw;
            else if (addr0) rd_val = {hi_in, {LANE_W{1'b0}}};
            else            rd_val = {{LANE_W{1'b0}}, lo_in};
         end
      end
   endgenerate

endmodule

// File: rtl/mbus_alatch.sv
module mbus_alatch #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ale,
   input  logic [W-1:0] bus_in,
   output logic [W-1:0] lat_out
);

   logic [W-1:0] hold_q;

   // Open while the strobe is high, closed on its falling edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hold_q <= '0;
      else if (ale) hold_q <= bus_in;
   end

   assign lat_out = ale ? bus_in : hold_q;

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
   import mbus_pkg::*;
#(
   parameter int ADDR_W        = 20,
   parameter int LANE_W        = 8,
   parameter bit BYTE_RD_ALIGN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic                       req_write,
   input  logic                       req_io,
   input  logic                       req_word,
   input  logic [2*LANE_W-1:0]        req_wdata,
   output logic                       rsp_done,
   output logic [2*LANE_W-1:0]        rsp_rdata,
   output logic                       bus_ale,
   output logic                       bus_mem,
   output logic                       bus_bhe_n,
   output logic                       bus_rd_n,
   output logic                       bus_wr_n,
   output logic [2*LANE_W-1:0]        bus_ad_out,
   output logic                       bus_ad_oe,
   input  logic [2*LANE_W-1:0]        bus_ad_in,
   output logic [ADDR_W-2*LANE_W-1:0] bus_a_hi,
   input  logic                       bus_ready,
   output logic [ADDR_W-1:0]          lat_addr
);

   localparam int DATA_W = 2 * LANE_W;
   localparam int HI_W   = ADDR_W - DATA_W;

   initial begin
      if (LANE_W < 1)
         $fatal(1, "mbus_seq: LANE_W must be at least 1");
      if (ADDR_W <= DATA_W)
         $fatal(1, "mbus_seq: ADDR_W must exceed the shared bus width");
   end

   bus_phase_e phase;
   logic       accept, sample;

   logic [ADDR_W-1:0] q_addr;
   logic              q_write, q_io, q_word;
   logic [DATA_W-1:0] q_wdata;
   logic [DATA_W-1:0] rdata_q;

   logic              a0, bhe_n_raw;
   logic [DATA_W-1:0] wlane, rd_val;
   logic              busy;

   mbus_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .bus_ready (bus_ready),
      .phase     (phase),
      .accept    (accept),
      .sample    (sample)
   );

   // Request is frozen for the whole cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_addr  <= '0;
         q_write <= 1'b0;
         q_io    <= 1'b0;
         q_word  <= 1'b0;
         q_wdata <= '0;
      end else if (accept) begin
         q_addr  <= req_addr;
         q_write <= req_write;
         q_io    <= req_io;
         q_word  <= req_word;
         q_wdata <= req_wdata;
      end
   end

   mbus_lane #(
      .LANE_W        (LANE_W),
      .BYTE_RD_ALIGN (BYTE_RD_ALIGN)
   ) u_lane (
      .word   (q_word),
      .addr0  (q_addr[0]),
      .wdata  (q_wdata),
      .rd_raw (bus_ad_in),
      .a0     (a0),
      .bhe_n  (bhe_n_raw),
      .wlane  (wlane),
      .rd_val (rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rdata_q <= '0;
      else if (sample && !q_write) rdata_q <= rd_val;
   end

   assign busy = (phase != PH_IDLE);

   // Phase decode of the bus pins
   always_comb begin
      bus_ale    = (phase == PH_T1);
      bus_mem    = busy ? ~q_io : 1'b0;
      bus_bhe_n  = busy ? bhe_n_raw : 1'b1;
      bus_a_hi   = busy ? q_addr[ADDR_W-1:DATA_W] : '0;
      bus_rd_n   = 1'b1;
      bus_wr_n   = 1'b1;
      bus_ad_oe  = 1'b0;
      bus_ad_out = '0;
      if (phase == PH_T1) begin
         bus_ad_oe  = 1'b1;
         bus_ad_out = {q_addr[DATA_W-1:1], a0};
      end else if (is_data_phase(phase)) begin
         if (q_write) begin
            bus_wr_n   = 1'b0;
            bus_ad_oe  = 1'b1;
            bus_ad_out = wlane;
         end else begin
            bus_rd_n = (phase == PH_T4);
         end
      end
   end

   assign rsp_done  = (phase == PH_T4);
   assign rsp_rdata = rdata_q;

   mbus_alatch #(
      .W (ADDR_W)
   ) u_alatch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ale     (bus_ale),
      .bus_in  ({bus_a_hi, bus_ad_out}),
      .lat_out (lat_addr)
   );

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk #(
   parameter int ADDR_W = 20,
   parameter int LANE_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rsp_done,
   input logic                  bus_ale,
   input logic                  bus_mem,
   input logic                  bus_bhe_n,
   input logic                  bus_rd_n,
   input logic                  bus_wr_n,
   input logic [2*LANE_W-1:0]   bus_ad_out,
   input logic                  bus_ad_oe,
   input logic [ADDR_W-1:0]     lat_addr
);

   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_ALE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |=> !bus_ale); // R2

   AST_ALE_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> (bus_ad_oe && bus_rd_n && bus_wr_n && !rsp_done)); // R2

   AST_MEM_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && (!bus_rd_n || !bus_wr_n || rsp_done)) |-> $stable(bus_mem)); // R3

   AST_BHE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && (!bus_rd_n || !bus_wr_n || rsp_done)) |-> $stable(bus_bhe_n)); // R4

   AST_ODD_BYTE_HIGH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ale && bus_ad_out[0]) |-> !bus_bhe_n); // R4

   AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> (!bus_ad_oe && bus_wr_n)); // R5

   AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> (bus_ad_oe && bus_rd_n)); // R6

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R10

   AST_LAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !bus_ale) |-> $stable(lat_addr)); // R12

endmodule

bind mbus_seq mbus_seq_chk #(
   .ADDR_W (ADDR_W),
   .LANE_W (LANE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rsp_done   (rsp_done),
   .bus_ale    (bus_ale),
   .bus_mem    (bus_mem),
   .bus_bhe_n  (bus_bhe_n),
   .bus_rd_n   (bus_rd_n),
   .bus_wr_n   (bus_wr_n),
   .bus_ad_out (bus_ad_out),
   .bus_ad_oe  (bus_ad_oe),
   .lat_addr   (lat_addr)
);

// File: tb/mbus_seq_test.sv
`timescale 1ns/1ps
module mbus_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [19:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_io = 1'b0;
   logic        req_word = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic        bus_ale, bus_mem, bus_bhe_n, bus_rd_n, bus_wr_n, bus_ad_oe;
   logic [15:0] bus_ad_out;
   logic [15:0] bus_ad_in = '0;
   logic [3:0]  bus_a_hi;
   logic        bus_ready = 1'b1;
   logic [19:0] lat_addr;

   always #2.5 clk = ~clk;

   mbus_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_io(req_io), .req_word(req_word),
      .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .bus_ale(bus_ale), .bus_mem(bus_mem), .bus_bhe_n(bus_bhe_n),
      .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ad_out(bus_ad_out),
      .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_a_hi(bus_a_hi),
      .bus_ready(bus_ready), .lat_addr(lat_addr)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // Reference model: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
   int          ph = 0;
   logic [19:0] m_addr = '0;
   logic        m_wr = 1'b0, m_io = 1'b0, m_word = 1'b0;
   logic [15:0] m_wd = '0;
   logic [15:0] m_rdata = '0;
   logic [19:0] m_lat = '0;
   bit          busy_req = 1'b0;
   int          waits_seen = 0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] lane_in(input logic [15:0] raw);
      if (m_word)         return raw;
      else if (m_addr[0]) return {8'h00, raw[15:8]};
      else                return {8'h00, raw[7:0]};
   endfunction

   always @(posedge clk) begin
      busy_req = 1'b0;
      if (!rst_n) begin
         ph = 0; m_rdata = '0; m_lat = '0;
      end else begin
         if (req_valid && ph != 0) busy_req = 1'b1;
         case (ph)
            0: if (req_valid) begin
                  m_addr = req_addr; m_wr = req_write; m_io = req_io;
                  m_word = req_word; m_wd = req_wdata; ph = 1;
               end
            1: begin
                  m_lat = {m_addr[19:1], m_word ? 1'b0 : m_addr[0]};
                  ph = 2;
               end
            2: ph = 3;
            3, 4: if (bus_ready) begin
                  if (!m_wr) m_rdata = lane_in(bus_ad_in);
                  ph = 5;
               end else begin
                  ph = 4; waits_seen++;
               end
            default: ph = 0;
         endcase
      end
   end

   // Stimulus for ready and inbound data, changed on falling edges
   int cyc_n = 0;
   always @(negedge clk) begin
      cyc_n++;
      bus_ready = ((cyc_n * 5 + cyc_n / 3) % 4) != 0;
      bus_ad_in = 16'hC35A ^ 16'(cyc_n * 16'h1357);
   end

   // Every-cycle comparison against the model
   always @(negedge clk) begin
      logic        a0e;
      logic        e_rd, e_wr, e_oe;
      logic [15:0] e_out;
      string       t;
      #0.1;
      a0e   = m_word ? 1'b0 : m_addr[0];
      e_rd  = !((ph >= 2 && ph <= 4) && !m_wr);
      e_wr  = !((ph >= 2) && m_wr);
      e_oe  = (ph == 1) || (ph >= 2 && m_wr);
      e_out = (ph == 1) ? {m_addr[15:1], a0e} :
              (ph >= 2 && m_wr) ? (m_word ? m_wd : {2{m_wd[7:0]}}) : 16'h0;
      if (!rst_n) begin
         chk("R1", "ale", bus_ale, 0);
         chk("R1", "rd_n", bus_rd_n, 1);
         chk("R1", "wr_n", bus_wr_n, 1);
         chk("R1", "oe", bus_ad_oe, 0);
         chk("R1", "bhe_n", bus_bhe_n, 1);
         chk("R1", "done", rsp_done, 0);
         chk("R1", "rdata", rsp_rdata, 0);
         chk("R1", "lat", lat_addr, 0);
      end else if (!finished) begin
         t = busy_req ? "R11" : (ph == 0 ? "R1" : "R2");
         chk(t, "ale", bus_ale, ph == 1);
         chk(ph == 0 ? "R1" : "R2", "a_hi", bus_a_hi, ph != 0 ? m_addr[19:16] : 4'h0);
         chk(ph == 0 ? "R1" : "R3", "mem", bus_mem, ph != 0 ? !m_io : 1'b0);
         chk(ph == 0 ? "R1" : "R4", "bhe_n", bus_bhe_n, ph != 0 ? !(m_word || m_addr[0]) : 1'b1);
         chk(ph == 4 ? "R8" : "R5", "rd_n", bus_rd_n, e_rd);
         chk("R6", "wr_n", bus_wr_n, e_wr);
         chk(ph == 1 ? "R2" : (m_wr ? "R6" : "R5"), "oe", bus_ad_oe, e_oe);
         chk(ph == 1 ? "R4" : "R7", "ad_out", bus_ad_out, e_out);
         chk(ph == 4 ? "R8" : "R10", "done", rsp_done, ph == 5);
         chk("R9", "rdata", rsp_rdata, m_rdata);
         chk("R12", "lat", lat_addr, ph == 1 ? {m_addr[19:1], a0e} : m_lat);
      end
   end

   task automatic issue(input int i);
      logic [19:0] a;
      a = 20'h5A3C6 ^ 20'(i * 20'h1F3B5);
      a[0] = i[2];
      while (ph != 0) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_write = i[0];
      req_word  = i[1];
      req_io    = i[3];
      req_wdata = 16'h8E21 ^ 16'(i * 16'h2B4D);
      @(negedge clk);
      if (i % 3 == 1) begin
         // R11: conflicting request while busy must be ignored
         req_addr  = ~a;
         req_write = ~req_write;
         req_word  = ~req_word;
         req_wdata = ~req_wdata;
         @(negedge clk);
         @(negedge clk);
      end
      req_valid = 1'b0;
      repeat (i % 2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 40; i++) issue(i);
      while (ph != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      n_chk++;
      if (waits_seen == 0) begin
         n_bad++;
         $display("FAIL R8 wait phases: actual %0d expected >0", waits_seen);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule